// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block is the software-visible register file of a four-channel DMA controller with 16-bit address and transfer counters. It sits on an 8-bit I/O bus with a 4-bit offset. Each channel's address and count registers are 16 bits wide. They are reached one byte at a time through a single shared byte pointer that selects the low or the high half and flips after every access. The control ports share the upper half of the offset space. They cover the command register, the status register, software requests, per-channel and group masking, per-channel mode, pointer reset and master clear.

The block drives every channel's mode, mask and current address and count to an external transfer engine. That engine pulses a per-channel step input once per completed transfer. Each step moves the current count down by one and moves the current address one place in the direction the mode selects. When a count wraps past zero, a terminal-count flag is raised in the status register. A channel in auto-reload mode restores its programmed base values at that point.

Top module: `dma_regif`

## Requirements
- R1: After reset, all four masks are set, and the command, request, terminal-count flags, modes, addresses and counts are zero. The byte pointer selects the low byte.
- R2: Offset 2n selects channel n's address register and offset 2n+1 selects its count register (n = 0..3). Each read or write of these registers moves the byte selected by the pointer (0 = bits [7:0], 1 = bits [15:8]) and then inverts the pointer. Any write to offset 12 returns the pointer to the low byte.
- R3: A byte written to an address or count register is stored in both the base copy and the current copy. Reads return the current copy.
- R4: A write to offset 10 selects a channel with data bits [1:0]. Data bit 2 = 1 masks that channel and data bit 2 = 0 unmasks it. The other masks are unchanged.
- R5: A write to offset 14 clears all four masks. A write to offset 15 loads mask n from data bit n.
- R6: A write to offset 11 selects a channel with data bits [1:0] and stores data bits [7:2] as that channel's 6-bit mode. Data bit 4 (mode bit 2) enables auto-reload. Data bit 5 (mode bit 3) makes the address count downward.
- R7: A write to offset 8 loads the 8-bit command register. A read of offset 8 returns {request[3:0], tc[3:0]} and then clears the tc flags. A flag raised in the same cycle as that read survives it.
- R8: A write to offset 9 selects a channel with data bits [1:0] and sets (data bit 2 = 1) or clears (data bit 2 = 0) its request bit.
- R9: A step on a channel whose count is not zero lowers the count by one and moves the address by one, up or down as its mode selects. A step is ignored in a cycle in which the bus writes that channel's address or count register.
- R10: A step on a channel whose count is 0x0000 sets that channel's tc flag. Without auto-reload the count becomes 0xFFFF and the address moves as in R9.
- R11: With auto-reload, the step that reaches terminal count loads the current address and count from the base copies instead.
- R12: A write to offset 13 resets the byte pointer, command, request bits and tc flags, and sets all four masks. Modes, addresses and counts keep their values.
- R13: Reads of offsets 9 through 15 return 0x00 and leave the byte pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (ignored when bus_wr is high) |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| eng_step | input | 4 | Per-channel transfer-done pulse from the engine |
| chan_addr_o | output | 64 | Current addresses, channel n at [16n+15:16n] |
| chan_count_o | output | 64 | Current counts, channel n at [16n+15:16n] |
| chan_mode_o | output | 24 | Modes, channel n at [6n+5:6n] |
| chan_mask_o | output | 4 | Mask bit per channel, 1 = masked |
| chan_tc_o | output | 4 | Terminal-count flags |
| cmd_o | output | 8 | Command register |
| req_o | output | 4 | Software request bits |

## Verification
The hardest cases are collisions within one cycle. The first is a bus write to a channel's register landing in the same cycle as an engine step on that channel. The second is a status read landing in the same cycle as a terminal count. The stimulus drives the bus strobe and the step vector together in a single cycle. It steps a second, unprogrammed channel in the same cycle, so that one channel's step is blocked while the other wraps from zero to 0xFFFF. Pointer state is tracked across pointer resets, master clear and reads of write-only offsets. A stray toggle then shows up as a byte landing in the wrong half.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int NUM_CH  = 4;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int REG_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int MODE_W  = 6;
    localparam int OFS_W   = 4;
    localparam int FLAT_W  = NUM_CH * REG_W;
    localparam int MFLAT_W = NUM_CH * MODE_W;

    // Mode field as stored: data bits [7:2] of a mode write.
    typedef struct packed {
        logic [1:0] xfer_kind;
        logic       addr_down;
        logic       auto_reload;
        logic [1:0] direction;
    } chan_mode_t;

    typedef enum logic [OFS_W-1:0] {
        PORT_CMD_STAT  = 4'd8,
        PORT_REQ       = 4'd9,
        PORT_SMASK     = 4'd10,
        PORT_MODE      = 4'd11,
        PORT_PTR_CLR   = 4'd12,
        PORT_MCLR_TEMP = 4'd13,
        PORT_MASK_CLR  = 4'd14,
        PORT_MASK_ALL  = 4'd15
    } ctl_port_e;

    typedef struct packed {
        logic [NUM_CH-1:0] wr_addr;
        logic [NUM_CH-1:0] wr_cnt;
        logic              chan_acc;
        logic              wr_cmd;
        logic              wr_req;
        logic              wr_smask;
        logic              wr_mode;
        logic              wr_ptr_clr;
        logic              wr_mclr;
        logic              wr_mask_clr;
        logic              wr_mask_all;
        logic              rd_status;
    } bus_dec_t;

    function automatic bus_dec_t decode_bus(input logic [OFS_W-1:0] ofs,
                                            input logic wr, input logic rd);
        bus_dec_t d;
        logic     rd_only;
        d       = '0;
        rd_only = rd & ~wr;
        if (!ofs[OFS_W-1]) begin
            d.chan_acc = wr | rd_only;
            if (wr) begin
                if (ofs[0]) d.wr_cnt[ofs[CH_W:1]]  = 1'b1;
                else        d.wr_addr[ofs[CH_W:1]] = 1'b1;
            end
        end else if (wr) begin
            case (ctl_port_e'(ofs))
                PORT_CMD_STAT:  d.wr_cmd      = 1'b1;
                PORT_REQ:       d.wr_req      = 1'b1;
                PORT_SMASK:     d.wr_smask    = 1'b1;
                PORT_MODE:      d.wr_mode     = 1'b1;
                PORT_PTR_CLR:   d.wr_ptr_clr  = 1'b1;
                PORT_MCLR_TEMP: d.wr_mclr     = 1'b1;
                PORT_MASK_CLR:  d.wr_mask_clr = 1'b1;
                PORT_MASK_ALL:  d.wr_mask_all = 1'b1;
                default:        d.wr_cmd      = 1'b0;
            endcase
        end else if (rd_only && ctl_port_e'(ofs) == PORT_CMD_STAT) begin
            d.rd_status = 1'b1;
        end
        return d;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [REG_W-1:0] v,
                                                    input logic hi);
        return hi ? v[REG_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic toggle,
    output logic hi
);
    always_ff @(posedge clk) begin
        if (rst || clear) hi <= 1'b0;
        else if (toggle)  hi <= ~hi;
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dmareg_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step,
    input  logic              addr_down,
    input  logic              auto_reload,
    output logic [W-1:0]      cur_addr,
    output logic [W-1:0]      cur_cnt,
    output logic              tc_evt
);
    localparam int LO_W = W - BYTE_W;

    logic [W-1:0] base_addr, base_cnt;
    logic         step_ok;
    logic [W-1:0] addr_next;

    assign step_ok   = step & ~wr_addr & ~wr_cnt;
    assign tc_evt    = step_ok & (cur_cnt == '0);
    assign addr_next = addr_down ? cur_addr - W'(1) : cur_addr + W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else if (wr_addr) begin
            if (hi_sel) begin
                base_addr[W-1:LO_W] <= wdata;
                cur_addr[W-1:LO_W]  <= wdata;
            end else begin
                base_addr[BYTE_W-1:0] <= wdata;
                cur_addr[BYTE_W-1:0]  <= wdata;
            end
        end else if (wr_cnt) begin
            if (hi_sel) begin
                base_cnt[W-1:LO_W] <= wdata;
                cur_cnt[W-1:LO_W]  <= wdata;
            end else begin
                base_cnt[BYTE_W-1:0] <= wdata;
                cur_cnt[BYTE_W-1:0]  <= wdata;
            end
        end else if (step_ok) begin
            if (tc_evt && auto_reload) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else begin
                cur_addr <= addr_next;
                cur_cnt  <= cur_cnt - W'(1);
            end
        end
    end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dmareg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_dec_t          dec,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [NUM_CH-1:0] tc_evt,
    output logic [NUM_CH-1:0] mask,
    output chan_mode_t        modes [NUM_CH],
    output logic [BYTE_W-1:0] cmd,
    output logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] tc
);
    logic [CH_W-1:0] sel;
    assign sel = wdata[CH_W-1:0];

    // Command, request and mask: master clear resets them together.
    always_ff @(posedge clk) begin
        if (rst || dec.wr_mclr) begin
            cmd  <= '0;
            req  <= '0;
            mask <= '1;
        end else begin
            if (dec.wr_cmd)      cmd       <= wdata;
            if (dec.wr_req)      req[sel]  <= wdata[2];
            if (dec.wr_smask)    mask[sel] <= wdata[2];
            if (dec.wr_mask_clr) mask      <= '0;
            if (dec.wr_mask_all) mask      <= wdata[NUM_CH-1:0];
        end
    end

    // Terminal-count flags: read clears, a new event wins over the clear.
    always_ff @(posedge clk) begin
        if (rst || dec.wr_mclr)  tc <= '0;
        else if (dec.rd_status)  tc <= tc_evt;
        else                     tc <= tc | tc_evt;
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
            always_ff @(posedge clk) begin
                if (rst)
                    modes[c] <= '0;
                else if (dec.wr_mode && sel == CH_W'(c))
                    modes[c] <= chan_mode_t'(wdata[BYTE_W-1:BYTE_W-MODE_W]);
            end
        end
    endgenerate
endmodule

// File: rtl/dma_regif.sv
module dma_regif
    import dmareg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [OFS_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]  bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [BYTE_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0]  eng_step,
    output logic [FLAT_W-1:0]  chan_addr_o,
    output logic [FLAT_W-1:0]  chan_count_o,
    output logic [MFLAT_W-1:0] chan_mode_o,
    output logic [NUM_CH-1:0]  chan_mask_o,
    output logic [NUM_CH-1:0]  chan_tc_o,
    output logic [BYTE_W-1:0]  cmd_o,
    output logic [NUM_CH-1:0]  req_o
);
    bus_dec_t          dec;
    logic              ptr_hi;
    logic [NUM_CH-1:0] tc_evt;
    logic [REG_W-1:0]  cur_addr [NUM_CH];
    logic [REG_W-1:0]  cur_cnt  [NUM_CH];
    chan_mode_t        modes    [NUM_CH];

    assign dec = decode_bus(bus_addr, bus_wr, bus_rd);

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .clear  (dec.wr_ptr_clr | dec.wr_mclr),
        .toggle (dec.chan_acc),
        .hi     (ptr_hi)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            dma_chan_regs #(.W(REG_W)) u_chan (
                .clk         (clk),
                .rst         (rst),
                .wr_addr     (dec.wr_addr[c]),
                .wr_cnt      (dec.wr_cnt[c]),
                .hi_sel      (ptr_hi),
                .wdata       (bus_wdata),
                .step        (eng_step[c]),
                .addr_down   (modes[c].addr_down),
                .auto_reload (modes[c].auto_reload),
                .cur_addr    (cur_addr[c]),
                .cur_cnt     (cur_cnt[c]),
                .tc_evt      (tc_evt[c])
            );
            assign chan_addr_o[c*REG_W +: REG_W]   = cur_addr[c];
            assign chan_count_o[c*REG_W +: REG_W]  = cur_cnt[c];
            assign chan_mode_o[c*MODE_W +: MODE_W] = modes[c];
        end
    endgenerate

    dma_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .wdata  (bus_wdata),
        .tc_evt (tc_evt),
        .mask   (chan_mask_o),
        .modes  (modes),
        .cmd    (cmd_o),
        .req    (req_o),
        .tc     (chan_tc_o)
    );

    // Read path: channel registers by pointer, status at offset 8, zero elsewhere.
    logic [CH_W-1:0]  rd_ch;
    logic [REG_W-1:0] rd_word;
    assign rd_ch   = bus_addr[CH_W:1];
    assign rd_word = bus_addr[0] ? cur_cnt[rd_ch] : cur_addr[rd_ch];

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && !bus_wr) begin
            if (!bus_addr[OFS_W-1])
                bus_rdata = pick_byte(rd_word, ptr_hi);
            else if (ctl_port_e'(bus_addr) == PORT_CMD_STAT)
                bus_rdata = {req_o, chan_tc_o};
        end
    end
endmodule

// File: rtl/dma_regif_chk.sv
module dma_regif_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [3:0] eng_step,
    input logic [3:0] mask,
    input logic [3:0] tc,
    input logic [15:0] cnt0,
    input logic       ptr_hi
);
    logic ch0_wr, mclr_wr;
    assign ch0_wr  = bus_wr && bus_addr[3:1] == 3'd0;
    assign mclr_wr = bus_wr && bus_addr == 4'd13;

    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && !bus_addr[3]) |=> ptr_hi != $past(ptr_hi)); // R2
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'd12) |=> !ptr_hi); // R2
    AST_SINGLE_MASK: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'd10) |=> mask[$past(bus_wdata[1:0])] == $past(bus_wdata[2])); // R4
    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'd14) |=> mask == 4'h0); // R5
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'd15) |=> mask == $past(bus_wdata[3:0])); // R5
    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == 4'd8 && eng_step == 4'h0) |=> tc == 4'h0); // R7
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (eng_step[0] && !ch0_wr && cnt0 != 16'h0) |=> cnt0 == $past(cnt0) - 16'd1); // R9
    AST_TC_RAISE: assert property (@(posedge clk) disable iff (rst)
        (eng_step[0] && !ch0_wr && !mclr_wr && cnt0 == 16'h0) |=> tc[0]); // R10
    AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        mclr_wr |=> (mask == 4'hF && tc == 4'h0 && !ptr_hi)); // R12
endmodule

bind dma_regif dma_regif_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .eng_step  (eng_step),
    .mask      (chan_mask_o),
    .tc        (chan_tc_o),
    .cnt0      (chan_count_o[15:0]),
    .ptr_hi    (ptr_hi)
);

// File: tb/dma_regif_test.sv
module dma_regif_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [3:0]  eng_step = '0;
    logic [63:0] chan_addr_o, chan_count_o;
    logic [23:0] chan_mode_o;
    logic [3:0]  chan_mask_o, chan_tc_o, req_o;
    logic [7:0]  cmd_o;

    always #5 clk = ~clk;

    dma_regif uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .eng_step(eng_step), .chan_addr_o(chan_addr_o), .chan_count_o(chan_count_o),
        .chan_mode_o(chan_mode_o), .chan_mask_o(chan_mask_o), .chan_tc_o(chan_tc_o),
        .cmd_o(cmd_o), .req_o(req_o)
    );

    int n_chk = 0;
    int n_err = 0;
    int n_cyc = 0;

    // Behavioural reference state
    logic [15:0] m_ba [4], m_ca [4], m_bc [4], m_cc [4];
    logic [5:0]  m_mode [4];
    logic [3:0]  m_mask, m_req, m_tc;
    logic [7:0]  m_cmd;
    logic        m_ptr;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_ba[c] = '0; m_ca[c] = '0; m_bc[c] = '0; m_cc[c] = '0; m_mode[c] = '0;
        end
        m_mask = 4'hF; m_req = '0; m_tc = '0; m_cmd = '0; m_ptr = 1'b0;
    endtask

    function automatic logic [7:0] model_read(input logic [3:0] a);
        logic [15:0] v;
        if (!a[3]) begin
            v = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
            return m_ptr ? v[15:8] : v[7:0];
        end
        if (a == 4'd8) return {m_req, m_tc};
        return 8'h00;
    endfunction

    task automatic model_next(input logic [3:0] a, input logic [7:0] d,
                              input logic w, input logic r, input logic [3:0] s);
        logic [3:0] tcn = '0;
        int bch = int'(a[2:1]);
        bit bwr = w && !a[3];
        for (int c = 0; c < 4; c++) begin
            if (s[c] && !(bwr && bch == c)) begin
                if (m_cc[c] == 16'h0) begin
                    tcn[c] = 1'b1;
                    if (m_mode[c][2]) begin
                        m_ca[c] = m_ba[c]; m_cc[c] = m_bc[c];
                    end else begin
                        m_cc[c] = 16'hFFFF;
                        m_ca[c] = m_mode[c][3] ? m_ca[c] - 16'd1 : m_ca[c] + 16'd1;
                    end
                end else begin
                    m_cc[c] = m_cc[c] - 16'd1;
                    m_ca[c] = m_mode[c][3] ? m_ca[c] - 16'd1 : m_ca[c] + 16'd1;
                end
            end
        end
        if (w) begin
            if (!a[3]) begin
                if (a[0]) begin
                    if (m_ptr) begin m_bc[bch][15:8] = d; m_cc[bch][15:8] = d; end
                    else       begin m_bc[bch][7:0]  = d; m_cc[bch][7:0]  = d; end
                end else begin
                    if (m_ptr) begin m_ba[bch][15:8] = d; m_ca[bch][15:8] = d; end
                    else       begin m_ba[bch][7:0]  = d; m_ca[bch][7:0]  = d; end
                end
                m_ptr = ~m_ptr;
            end else begin
                case (a)
                    4'd8:  m_cmd = d;
                    4'd9:  m_req[d[1:0]] = d[2];
                    4'd10: m_mask[d[1:0]] = d[2];
                    4'd11: m_mode[d[1:0]] = d[7:2];
                    4'd12: m_ptr = 1'b0;
                    4'd13: begin m_ptr = 1'b0; m_cmd = '0; m_req = '0; m_mask = 4'hF; end
                    4'd14: m_mask = 4'h0;
                    default: m_mask = d[3:0];
                endcase
            end
        end else if (r) begin
            if (!a[3]) m_ptr = ~m_ptr;
            else if (a == 4'd8) m_tc = '0;
        end
        m_tc = m_tc | tcn;
        if (w && a == 4'd13) m_tc = '0;
    endtask

    task automatic compare_all(input string tag);
        for (int c = 0; c < 4; c++) begin
            chk({tag, " R3/R9/R11 current address"}, chan_addr_o[16*c +: 16], m_ca[c]);
            chk({tag, " R9/R10/R11 current count"}, chan_count_o[16*c +: 16], m_cc[c]);
            chk({tag, " R6 mode"}, chan_mode_o[6*c +: 6], m_mode[c]);
        end
        chk({tag, " R4/R5/R12 masks"}, chan_mask_o, m_mask);
        chk({tag, " R7/R10 tc flags"}, chan_tc_o, m_tc);
        chk({tag, " R7/R12 command"}, cmd_o, m_cmd);
        chk({tag, " R8/R12 requests"}, req_o, m_req);
    endtask

    // One bus/engine cycle, entered and left at a falling edge.
    task automatic cyc(input logic [3:0] a, input logic [7:0] d, input logic w,
                       input logic r, input logic [3:0] s, input string tag);
        bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r; eng_step = s;
        #1;
        if (r && !w) chk({tag, " R2/R7/R13 read data"}, bus_rdata, model_read(a));
        model_next(a, d, w, r, s);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; eng_step = '0;
        compare_all(tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
        cyc(a, d, 1'b1, 1'b0, 4'h0, tag);
    endtask
    task automatic rd(input logic [3:0] a, input string tag);
        cyc(a, 8'h00, 1'b0, 1'b1, 4'h0, tag);
    endtask
    task automatic stp(input logic [3:0] s, input string tag);
        cyc(4'h0, 8'h00, 1'b0, 1'b0, s, tag);
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 20000) begin
            n_err++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1 reset");
        rd(4'd8, "R1 status after reset");

        // R2 R3: program channel 0 address 0x1234, count 0x0002, read back
        wr(4'd12, 8'h00, "R2 pointer clear");
        wr(4'd0, 8'h34, "R3 addr0 lo");
        wr(4'd0, 8'h12, "R3 addr0 hi");
        wr(4'd1, 8'h02, "R3 cnt0 lo");
        wr(4'd1, 8'h00, "R3 cnt0 hi");
        rd(4'd0, "R2 addr0 lo read");
        rd(4'd0, "R2 addr0 hi read");
        rd(4'd1, "R2 cnt0 lo read");
        rd(4'd1, "R2 cnt0 hi read");

        // R2: pointer clear in mid-pair
        wr(4'd2, 8'hAA, "R2 addr1 lo");
        wr(4'd12, 8'h5A, "R2 pointer clear mid");
        wr(4'd2, 8'h55, "R2 addr1 lo again");
        wr(4'd2, 8'h66, "R2 addr1 hi");

        // R13: reads of control offsets return zero, pointer untouched
        rd(4'd13, "R13 temp read");
        rd(4'd10, "R13 wo read");
        rd(4'd15, "R13 wo read");
        rd(4'd2, "R13 pointer still low");
        rd(4'd2, "R13 pointer high");

        // R4 R5: masking
        wr(4'd10, 8'h00, "R4 unmask ch0");
        wr(4'd10, 8'h02, "R4 unmask ch2");
        wr(4'd10, 8'h06, "R4 mask ch2");
        wr(4'd14, 8'hFF, "R5 clear all");
        wr(4'd15, 8'h0A, "R5 load masks");
        wr(4'd15, 8'hF5, "R5 load masks upper ignored");

        // R6: modes
        wr(4'd11, 8'h44, "R6 ch0 io-to-mem");
        wr(4'd11, 8'h48 | 8'h10 | 8'h01, "R6 ch1 mem-to-io autoreload");
        wr(4'd11, 8'hC2, "R6 ch2 cascade");
        wr(4'd11, 8'h66, "R6 ch2 decrement");
        wr(4'd11, 8'hC3, "R6 ch3 cascade");

        // R7 R8: command and requests
        wr(4'd8, 8'hA5, "R7 command");
        wr(4'd9, 8'h05, "R8 set req1");
        wr(4'd9, 8'h07, "R8 set req3");
        wr(4'd9, 8'h03, "R8 clear req3");
        rd(4'd8, "R7 status with request");

        // R9 R10: count down to terminal count
        stp(4'b0001, "R9 step 2->1");
        stp(4'b0001, "R9 step 1->0");
        stp(4'b0001, "R10 step wrap");
        rd(4'd1, "R10 finished count lo");
        rd(4'd1, "R10 finished count hi");
        rd(4'd8, "R7 status shows tc");
        rd(4'd8, "R7 status cleared");

        // R9: step blocked by bus write on ch0, ch2 wraps downward at the same time
        cyc(4'd0, 8'h00, 1'b1, 1'b0, 4'b0101, "R9 blocked step");
        wr(4'd0, 8'h20, "R9 addr0 hi");
        stp(4'b0001, "R9 step after block");

        // R11: auto-reload on channel 1
        wr(4'd3, 8'h01, "R11 cnt1 lo");
        wr(4'd3, 8'h00, "R11 cnt1 hi");
        stp(4'b0010, "R11 step 1->0");
        stp(4'b0010, "R11 reload");

        // R7: tc raised in the same cycle as a status read survives
        stp(4'b0010, "R7 prep");
        cyc(4'd8, 8'h00, 1'b0, 1'b1, 4'b0010, "R7 read with tc");
        rd(4'd8, "R7 survivor visible");

        // R12: master clear
        wr(4'd8, 8'h33, "R12 command");
        wr(4'd9, 8'h06, "R12 request");
        wr(4'd14, 8'h00, "R12 unmask");
        wr(4'd0, 8'h77, "R12 pointer to high");
        stp(4'b0100, "R12 raise tc");
        wr(4'd13, 8'h00, "R12 master clear");
        wr(4'd0, 8'h11, "R12 write lands low");
        rd(4'd0, "R12 read high");

        cyc(4'd0, 8'h00, 1'b0, 1'b0, 4'h0, "idle");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule